// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns a stream of bytes into asynchronous serial frames on one output line. A small set of byte-wide registers, written through a simple write port, sets the frame shape, the pause rules and the line state. The frame shape covers 7 or 8 data bits, five parity choices, and 1 or 2 stop bits. A bit-tick strobe from an external baud generator paces every bit. Bytes arrive on a valid/ready handshake. A frame is accepted only in a cycle where the strobe is high, so every bit, the start bit included, lasts exactly one tick period.

Transmission can be held back in three ways. A hardware clear-to-send input can hold it. A pause state can hold it, set and cleared when a companion receiver reports the programmed stop and resume characters. A forced-low break condition can also hold it. The transmit-enable bit gates the start of new frames. The receive-enable bit gates whether received characters can change the pause state. The flow-mode register is locked while either enable bit is set.

Top module: `uart_fmt_tx`

## Requirements
- R1: After reset the line is high and tx_ready_o is low. Reset values: enable 0, format 0x08, flow mode 0, resume character 0x11, stop character 0x13, break off.
- R2: A frame is a start bit (0), then the data bits least significant first, then optional parity, then stop bits (1). Each bit lasts one tick period. tx_ready_o is high only in a cycle where tick_i is high and no frame is active. The line goes high for at least one tick period between frames.
- R3: Format register (address 1) bits [3:0] equal to 7 select 7 data bits. Any other value selects 8.
- R4: Format bits [6:4] set the parity bit: 0 none, 1 odd, 2 even, 3 always 1, 4 always 0. Codes 5 to 7 mean none. Parity covers only the transmitted data bits.
- R5: Format bit 7 set to 0 sends one stop bit; set to 1 it sends two.
- R6: The format is captured when a byte is accepted. A format write during a frame affects only later frames.
- R7: Writing a nonzero value such as 0xFF to the break register (address 5) drives the line low from the next cycle and aborts any frame. No byte is accepted while break is on. Writing 0 releases the line. After release the line stays high for at least one full tick period before the next accept.
- R8: Enable register (address 0) bit 0 gates the acceptance of new bytes. Clearing it lets a frame in progress finish.
- R9: Flow mode 1 (hardware): no byte is accepted while cts_i is low. A frame in progress finishes when cts_i falls.
- R10: Flow mode 2 (software): a received character equal to the stop register (address 4) pauses acceptance after the current frame. One equal to the resume register (address 3) lifts the pause. The stop match wins if both registers are equal. Received characters are ignored unless enable bit 1 is set.
- R11: A write to the flow register (address 2) takes effect only when enable bits [1:0] are both 0. It also clears the pause state. Flow code 0 and code 3 mean no flow control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| tick_i | input | 1 | One-cycle bit-time strobe |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte present |
| tx_ready_o | output | 1 | Byte accepted this cycle when valid |
| cts_i | input | 1 | Clear to send, high permits new frames |
| rx_char_i | input | 8 | Character from the companion receiver |
| rx_char_valid_i | input | 1 | rx_char_i is valid this cycle |
| txd_o | output | 1 | Serial line, idles high |

## Verification
The corner cases are these:
- The 7-bit length with each parity code. A design that computed parity over all eight bits would flip the parity bit whenever bit 7 of the byte is set.
- A format write made mid-frame. A design that read the live register would change the stop or parity bits of the frame already on the line.
- A break asserted in the middle of a data bit. A design that only gated the output, without aborting, would resume a torn frame after release.
- A design without the guard period would start a new start bit right after the release.
- Falling clear-to-send and a received stop character during an active frame. Each must let that frame finish and block only the next one.
- A flow-mode write while enabled must be dropped. A design that missed the lock would switch to hardware flow and stall on a low clear-to-send.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = $clog2(BYTE_W);
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd0;
  localparam logic [ADDR_W-1:0] A_FORMAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLOW   = 3'd2;
  localparam logic [ADDR_W-1:0] A_XON    = 3'd3;
  localparam logic [ADDR_W-1:0] A_XOFF   = 3'd4;
  localparam logic [ADDR_W-1:0] A_BREAK  = 3'd5;

  localparam logic [3:0]        LEN_SHORT = 4'd7;
  localparam logic [BYTE_W-1:0] FMT_RST   = 8'h08;
  localparam logic [BYTE_W-1:0] XON_RST   = 8'h11;
  localparam logic [BYTE_W-1:0] XOFF_RST  = 8'h13;

  typedef enum logic [1:0] {
    FLOW_OFF  = 2'd0,
    FLOW_HW   = 2'd1,
    FLOW_SW   = 2'd2,
    FLOW_RSVD = 2'd3
  } flow_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK, ST_GUARD
  } tx_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic [IDX_W-1:0]  last_idx;
    logic              par_en;
    logic              par_bit;
    logic              two_stop;
  } frame_t;
endpackage

// File: rtl/uart_fmt_regs.sv
module uart_fmt_regs import uart_fmt_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [1:0]        en_o,
  output logic [BYTE_W-1:0] fmt_o,
  output flow_e             flow_o,
  output logic [BYTE_W-1:0] xon_o,
  output logic [BYTE_W-1:0] xoff_o,
  output logic              brk_o,
  output logic              flow_wr_o
);
  logic hit_flow;

  // flow mode is locked while either direction is enabled
  assign hit_flow  = we_i && (addr_i == A_FLOW) && (en_o == 2'b00);
  assign flow_wr_o = hit_flow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 2'b00;
      fmt_o  <= FMT_RST;
      flow_o <= FLOW_OFF;
      xon_o  <= XON_RST;
      xoff_o <= XOFF_RST;
      brk_o  <= 1'b0;
    end else begin
      if (we_i && addr_i == A_ENABLE) en_o   <= wdata_i[1:0];
      if (we_i && addr_i == A_FORMAT) fmt_o  <= wdata_i;
      if (hit_flow)                   flow_o <= flow_e'(wdata_i[1:0]);
      if (we_i && addr_i == A_XON)    xon_o  <= wdata_i;
      if (we_i && addr_i == A_XOFF)   xoff_o <= wdata_i;
      if (we_i && addr_i == A_BREAK)  brk_o  <= |wdata_i;
    end
  end
endmodule

// File: rtl/uart_fmt_flow.sv
module uart_fmt_flow import uart_fmt_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  flow_e             flow_i,
  input  logic              rx_en_i,
  input  logic              flow_wr_i,
  input  logic [BYTE_W-1:0] xon_i,
  input  logic [BYTE_W-1:0] xoff_i,
  input  logic [BYTE_W-1:0] rx_char_i,
  input  logic              rx_char_valid_i,
  input  logic              cts_i,
  output logic              permit_o
);
  logic paused_q;
  logic rx_take;

  assign rx_take = rx_en_i && rx_char_valid_i && (flow_i == FLOW_SW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           paused_q <= 1'b0;
    else if (flow_wr_i)                    paused_q <= 1'b0;
    else if (rx_take && rx_char_i == xoff_i) paused_q <= 1'b1;
    else if (rx_take && rx_char_i == xon_i)  paused_q <= 1'b0;
  end

  always_comb begin
    unique case (flow_i)
      FLOW_HW: permit_o = cts_i;
      FLOW_SW: permit_o = !paused_q;
      default: permit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_fmt_dec.sv
module uart_fmt_dec import uart_fmt_pkg::*; (
  input  logic [BYTE_W-1:0] fmt_i,
  input  logic [BYTE_W-1:0] data_i,
  output frame_t            frame_o
);
  logic              short_len;
  logic [BYTE_W-1:0] used;

  assign short_len = (fmt_i[3:0] == LEN_SHORT);
  // parity covers only bits that go on the line
  assign used = short_len ? {1'b0, data_i[BYTE_W-2:0]} : data_i;

  always_comb begin
    frame_o.data     = data_i;
    frame_o.last_idx = short_len ? IDX_W'(BYTE_W - 2) : IDX_W'(BYTE_W - 1);
    frame_o.two_stop = fmt_i[7];
    frame_o.par_en   = 1'b1;
    frame_o.par_bit  = 1'b0;
    unique case (fmt_i[6:4])
      3'd1:    frame_o.par_bit = ~^used;
      3'd2:    frame_o.par_bit = ^used;
      3'd3:    frame_o.par_bit = 1'b1;
      3'd4:    frame_o.par_bit = 1'b0;
      default: frame_o.par_en  = 1'b0;
    endcase
  end
endmodule

// File: rtl/uart_fmt_ser.sv
module uart_fmt_ser import uart_fmt_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      start_i,
  input  frame_t    frame_i,
  input  logic      brk_i,
  output logic      line_o,
  output logic      idle_o,
  output tx_state_e state_o
);
  tx_state_e        st_q;
  frame_t           fr_q;
  logic [IDX_W-1:0] idx_q;
  logic             stop2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      fr_q    <= '0;
      idx_q   <= '0;
      stop2_q <= 1'b0;
    end else if (brk_i) begin
      st_q <= ST_BRK;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          fr_q <= frame_i;
          st_q <= ST_START;
        end
        ST_START: if (tick_i) begin
          idx_q <= '0;
          st_q  <= ST_DATA;
        end
        ST_DATA: if (tick_i) begin
          if (idx_q == fr_q.last_idx) begin
            stop2_q <= 1'b0;
            st_q    <= fr_q.par_en ? ST_PAR : ST_STOP;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_PAR: if (tick_i) begin
          stop2_q <= 1'b0;
          st_q    <= ST_STOP;
        end
        ST_STOP: if (tick_i) begin
          if (fr_q.two_stop && !stop2_q) stop2_q <= 1'b1;
          else                           st_q    <= ST_IDLE;
        end
        ST_BRK:   st_q <= ST_GUARD;
        ST_GUARD: if (tick_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = fr_q.data[idx_q];
      ST_PAR:   line_o = fr_q.par_bit;
      default:  line_o = 1'b1;
    endcase
  end

  assign idle_o  = (st_q == ST_IDLE);
  assign state_o = st_q;
endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx import uart_fmt_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  input  logic              tick_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic              cts_i,
  input  logic [BYTE_W-1:0] rx_char_i,
  input  logic              rx_char_valid_i,
  output logic              txd_o
);
  logic [1:0]        en_w;
  logic [BYTE_W-1:0] fmt_w, xon_w, xoff_w;
  flow_e             flow_w;
  logic              brk_w, flow_wr_w, permit_w, idle_w, line_w;
  frame_t            frame_w;
  tx_state_e         st_w;

  uart_fmt_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .en_o(en_w), .fmt_o(fmt_w), .flow_o(flow_w), .xon_o(xon_w),
    .xoff_o(xoff_w), .brk_o(brk_w), .flow_wr_o(flow_wr_w)
  );

  uart_fmt_flow u_flow (
    .clk_i, .rst_ni,
    .flow_i(flow_w), .rx_en_i(en_w[1]), .flow_wr_i(flow_wr_w),
    .xon_i(xon_w), .xoff_i(xoff_w),
    .rx_char_i, .rx_char_valid_i, .cts_i,
    .permit_o(permit_w)
  );

  uart_fmt_dec u_dec (.fmt_i(fmt_w), .data_i(tx_data_i), .frame_o(frame_w));

  assign tx_ready_o = idle_w && tick_i && en_w[0] && !brk_w && permit_w;

  uart_fmt_ser u_ser (
    .clk_i, .rst_ni, .tick_i,
    .start_i(tx_ready_o && tx_valid_i), .frame_i(frame_w), .brk_i(brk_w),
    .line_o(line_w), .idle_o(idle_w), .state_o(st_w)
  );

  assign txd_o = line_w && !brk_w;
endmodule

// File: rtl/uart_fmt_tx_chk.sv
module uart_fmt_tx_chk import uart_fmt_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              tx_ready_o,
  input logic              txd_o,
  input logic              cts_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [BYTE_W-1:0] reg_wdata_i,
  input logic [1:0]        en_q,
  input flow_e             flow_q,
  input tx_state_e         ser_state
);
  a_r2_ready_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> tick_i);
  a_r8_ready_needs_tx_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> en_q[0]);
  a_r9_cts_blocks_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && flow_q == FLOW_HW) |-> cts_i);
  a_r7_break_drives_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_BREAK && reg_wdata_i != '0) |=> !txd_o);
  a_r7_no_accept_in_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_state == ST_BRK || ser_state == ST_GUARD) |-> !tx_ready_o);
  a_r11_flow_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_FLOW && en_q != 2'b00) |=> $stable(flow_q));
endmodule

bind uart_fmt_tx uart_fmt_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .tx_ready_o(tx_ready_o),
  .txd_o(txd_o), .cts_i(cts_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .en_q(en_w), .flow_q(flow_w), .ser_state(st_w)
);

// File: tb/uart_fmt_tx_tb.sv
module uart_fmt_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       tick = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       cts = 1'b1;
  logic [7:0] rx_char = '0;
  logic       rx_valid = 1'b0;
  logic       txd;

  int    checks = 0, errors = 0, frames = 0, cyc = 0;
  string tag = "R1";
  logic  ready_obs = 1'b0, txd_obs = 1'b1;
  byte   src_q[$];

  // reference model state
  logic [1:0] m_en;  logic [7:0] m_fmt, m_xon, m_xoff;
  logic [1:0] m_flow; logic m_brk, m_paused, m_lvl;
  int    m_mode;  // 0 idle, 1 busy, 2 break, 3 guard
  bit    m_bits[$];

  always #5 clk = ~clk;

  uart_fmt_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .tick_i(tick), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .cts_i(cts),
    .rx_char_i(rx_char), .rx_char_valid_i(rx_valid), .txd_o(txd)
  );

  task automatic check(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  task automatic build(input byte d, input logic [7:0] f);
    int n, ones;
    n = (f[3:0] == 4'd7) ? 7 : 8;
    ones = 0;
    m_bits.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      m_bits.push_back(d[i]);
      ones += d[i];
    end
    case (f[6:4])
      3'd1: m_bits.push_back((ones % 2) == 0);
      3'd2: m_bits.push_back((ones % 2) == 1);
      3'd3: m_bits.push_back(1'b1);
      3'd4: m_bits.push_back(1'b0);
      default: ;
    endcase
    m_bits.push_back(1'b1);
    if (f[7]) m_bits.push_back(1'b1);
  endtask

  always @(negedge clk) begin
    cyc++;
    tick     <= (cyc % 4 == 0);
    tx_valid <= (src_q.size() > 0);
    tx_data  <= (src_q.size() > 0) ? src_q[0] : 8'h00;
  end

  always @(negedge clk) begin
    #1;
    ready_obs = tx_ready;
    txd_obs   = txd;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_fmt = 8'h08; m_flow = 0; m_xon = 8'h11; m_xoff = 8'h13;
      m_brk = 0; m_paused = 0; m_mode = 0; m_lvl = 1; m_bits.delete();
    end else begin
      logic ok_flow, exp_ready, hs;
      ok_flow = (m_flow == 2'd1) ? cts : (m_flow == 2'd2) ? !m_paused : 1'b1;
      exp_ready = (m_mode == 0) && tick && m_en[0] && !m_brk && ok_flow;
      check(ready_obs == exp_ready, tag, ready_obs, exp_ready);
      check(txd_obs == (m_brk ? 1'b0 : m_lvl), tag, txd_obs, m_brk ? 0 : m_lvl);
      hs = exp_ready && tx_valid;
      if (m_brk) begin
        m_mode = 2; m_lvl = 1; m_bits.delete();
      end else begin
        case (m_mode)
          0: if (hs) begin
            build(src_q[0], m_fmt);
            void'(src_q.pop_front());
            frames++;
            m_lvl = m_bits.pop_front();
            m_mode = 1;
          end
          1: if (tick) begin
            if (m_bits.size() == 0) begin m_mode = 0; m_lvl = 1; end
            else m_lvl = m_bits.pop_front();
          end
          2: begin m_mode = 3; m_lvl = 1; end
          default: if (tick) m_mode = 0;
        endcase
      end
      if (rx_valid && m_en[1] && m_flow == 2'd2) begin
        if (rx_char == m_xoff) m_paused = 1;
        else if (rx_char == m_xon) m_paused = 0;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_en = reg_wdata[1:0];
          3'd1: m_fmt = reg_wdata;
          3'd2: if (m_en == 2'b00) begin m_flow = reg_wdata[1:0]; m_paused = 0; end
          3'd3: m_xon = reg_wdata;
          3'd4: m_xoff = reg_wdata;
          3'd5: m_brk = (reg_wdata != 0);
          default: ;
        endcase
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rx(input logic [7:0] c);
    @(negedge clk); rx_valid = 1; rx_char = c;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic idle_wait();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (src_q.size() == 0 && m_mode == 0) break;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic frames_wait(input int n);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (frames >= n) break;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int base;
    logic [7:0] fmts [9] = '{8'h08, 8'h17, 8'h27, 8'h38, 8'h47, 8'h88, 8'h9F, 8'h05, 8'h57};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(txd_obs == 1'b1, "R1 line idle", txd_obs, 1);
    check(ready_obs == 1'b0, "R1 ready", ready_obs, 0);

    // R8: byte waits while transmit disabled
    tag = "R8";
    src_q.push_back(8'h55);
    repeat (60) @(negedge clk);
    check(frames == 0, "R8 disabled accept", frames, 0);
    wr(3'd0, 8'h01);
    idle_wait();
    check(frames == 1, "R8 enabled accept", frames, 1);

    // R2..R5 format sweep
    foreach (fmts[k]) begin
      tag = (k == 0) ? "R2" : (fmts[k][6:4] != 0) ? "R4" : (fmts[k][7]) ? "R5" : "R3";
      wr(3'd1, fmts[k]);
      src_q.push_back(8'hA5); src_q.push_back(8'h3C); src_q.push_back(8'hFF);
      base = frames;
      idle_wait();
      check(frames == base + 3, tag, frames, base + 3);
    end

    // R6 mid-frame format change
    tag = "R6";
    wr(3'd1, 8'h08);
    base = frames;
    src_q.push_back(8'h81); src_q.push_back(8'h7E); src_q.push_back(8'hC3);
    frames_wait(base + 1);
    repeat (10) @(negedge clk);
    wr(3'd1, 8'hB7);
    idle_wait();
    check(frames == base + 3, "R6 frames", frames, base + 3);

    // R7 break mid-frame, release, guard
    tag = "R7";
    wr(3'd1, 8'h08);
    base = frames;
    src_q.push_back(8'hF0); src_q.push_back(8'h0F);
    frames_wait(base + 1);
    repeat (13) @(negedge clk);
    wr(3'd5, 8'hFF);
    repeat (40) @(negedge clk);
    check(txd_obs == 1'b0, "R7 held low", txd_obs, 0);
    check(frames == base + 1, "R7 no accept", frames, base + 1);
    wr(3'd5, 8'h00);
    idle_wait();
    check(frames == base + 2, "R7 resume", frames, base + 2);

    // R8 disable mid-frame lets frame finish
    tag = "R8";
    base = frames;
    src_q.push_back(8'h11); src_q.push_back(8'h22); src_q.push_back(8'h33);
    frames_wait(base + 1);
    wr(3'd0, 8'h00);
    repeat (200) @(negedge clk);
    check(frames == base + 1, "R8 disable", frames, base + 1);
    check(txd_obs == 1'b1, "R8 finished high", txd_obs, 1);
    src_q.delete();
    wr(3'd0, 8'h01);

    // R11 flow write ignored while enabled
    tag = "R11";
    wr(3'd2, 8'h01);
    cts = 0;
    base = frames;
    src_q.push_back(8'h5A);
    idle_wait();
    check(frames == base + 1, "R11 locked", frames, base + 1);

    // R9 hardware flow
    tag = "R9";
    wr(3'd0, 8'h00); wr(3'd2, 8'h01); wr(3'd0, 8'h01);
    base = frames;
    src_q.push_back(8'h96); src_q.push_back(8'h69);
    repeat (100) @(negedge clk);
    check(frames == base, "R9 cts low", frames, base);
    cts = 1;
    frames_wait(base + 1);
    repeat (6) @(negedge clk);
    cts = 0;
    repeat (150) @(negedge clk);
    check(frames == base + 1, "R9 mid-frame", frames, base + 1);
    cts = 1;
    idle_wait();
    check(frames == base + 2, "R9 resume", frames, base + 2);

    // R10 software flow
    tag = "R10";
    wr(3'd0, 8'h00); wr(3'd2, 8'h02); wr(3'd0, 8'h03);
    cts = 0;
    rx(8'h13);
    base = frames;
    src_q.push_back(8'h01); src_q.push_back(8'h02);
    repeat (100) @(negedge clk);
    check(frames == base, "R10 paused", frames, base);
    rx(8'h11);
    idle_wait();
    check(frames == base + 2, "R10 resumed", frames, base + 2);
    wr(3'd0, 8'h01);
    rx(8'h13);
    base = frames;
    src_q.push_back(8'h03);
    idle_wait();
    check(frames == base + 1, "R10 rx disabled", frames, base + 1);
    wr(3'd4, 8'hAB); wr(3'd0, 8'h03);
    rx(8'hAB);
    base = frames;
    src_q.push_back(8'h04);
    repeat (100) @(negedge clk);
    check(frames == base, "R10 custom stop", frames, base);
    rx(8'h11);
    idle_wait();
    check(frames == base + 1, "R10 custom resume", frames, base + 1);

    // R11 code 3 means no flow control, write clears pause
    tag = "R11";
    rx(8'hAB);
    wr(3'd0, 8'h00); wr(3'd2, 8'h03); wr(3'd0, 8'h01);
    base = frames;
    src_q.push_back(8'h77);
    idle_wait();
    check(frames == base + 1, "R11 code 3", frames, base + 1);
    cts = 1;
    finish_run();
  end
endmodule